// File: doc/BRIEF.md
# Bit-Manipulation and Conditional-Move Execution Unit

This unit executes one of fifteen 64-bit integer operations per accepted request: scaled addition, rotate right by an immediate (full and word width), signed and unsigned bit-field extraction, leading-zero counts of the operand or its inverse, full and word byte reversal, a zero-byte lane test, a single-bit test, and the conditional moves on zero and non-zero. It sits beside the main integer pipe. Decode supplies the operation code, the register values and the immediate fields. The result, a write strobe and an illegal strobe come back one clock later. Register-file access and instruction decode are handled elsewhere.

The result register loads only on cycles where a request is presented, so the last result stays readable. The write and illegal strobes are single-cycle pulses that follow each request. The conditional moves receive the destination's present value on a separate operand so that a move that is not taken writes back that same value.

Top module: `vbm_alu`

## Requirements
- R1: Outputs are registered with one cycle of latency. After reset `res` is 0 and `wr_en` and `illegal` are 0. A cycle without `op_valid` produces no `wr_en` or `illegal` pulse in the following cycle.
- R2: Codes 0, 1 and 2 return `src_a + (src_b << n)` with n = 1, 2 and 3 respectively, truncated to 64 bits. The shift applies to `src_b`.
- R3: Code 3 rotates `src_a` right by `imm_sh` (0..63). Code 4 rotates `src_a[31:0]` right by `imm_sh[4:0]` and sign-extends the 32-bit result from its bit 31.
- R4: Code 5 returns `src_a[imm_msb:imm_lsb]` sign-extended from the field's top bit. Code 6 returns the same field zero-extended.
- R5: For codes 5 and 6 with `imm_lsb > imm_msb`, `illegal` pulses, `wr_en` stays 0 and `res` becomes 0.
- R6: Code 7 returns the number of leading zeros of `~src_a`. Code 8 returns the number of leading zeros of `src_a`. An all-zero count input gives 64.
- R7: Code 9 reverses the order of all eight bytes of `src_a`. Code 10 reverses the four bytes of `src_a[31:0]` and sign-extends the result from its bit 31.
- R8: Code 11 sets each byte lane of the result to 0xFF where the matching byte of `src_a` is zero, and to 0x00 otherwise.
- R9: Code 12 returns `src_a[imm_sh]` in bit 0, and all other bits are 0.
- R10: Code 13 returns `src_a` when `src_b` is zero, and otherwise returns `src_old`. Code 14 returns `src_a` when `src_b` is non-zero, and otherwise returns `src_old`. Both assert `wr_en`.
- R11: Code 15 is undefined. It pulses `illegal`, keeps `wr_en` at 0 and loads `res` with 0. Every legal request pulses `wr_en` and keeps `illegal` at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_valid | input | 1 | Request present this cycle |
| op_code | input | 4 | Operation select (codes listed in the requirements) |
| src_a | input | 64 | First operand |
| src_b | input | 64 | Second operand (scaled-add addend, move condition) |
| src_old | input | 64 | Present destination value for conditional moves |
| imm_sh | input | 6 | Rotate amount or tested bit index |
| imm_msb | input | 6 | Upper bound of the extracted field |
| imm_lsb | input | 6 | Lower bound of the extracted field |
| res | output | 64 | Result, held between requests |
| wr_en | output | 1 | Write strobe, one cycle after a legal request |
| illegal | output | 1 | Illegal strobe, one cycle after a rejected request |

## Verification
Every result, the write strobe and the illegal strobe are due on the first rising edge after the request cycle. No output is combinational from the inputs. The bench drives each request on a falling edge and removes `op_valid` on the next falling edge, which falls half a period after the capturing edge. It compares all three outputs at that point, so each check sees exactly one registered result. A later idle cycle confirms that the strobes drop while `res` holds its value.

// File: rtl/vbm_pkg.sv
package vbm_pkg;

  typedef enum logic [3:0] {
    OP_SADD1  = 4'd0,
    OP_SADD2  = 4'd1,
    OP_SADD3  = 4'd2,
    OP_ROR    = 4'd3,
    OP_RORW   = 4'd4,
    OP_EXTS   = 4'd5,
    OP_EXTU   = 4'd6,
    OP_CLO    = 4'd7,
    OP_CLZ    = 4'd8,
    OP_REV    = 4'd9,
    OP_REVW   = 4'd10,
    OP_ZBYTE  = 4'd11,
    OP_BTEST  = 4'd12,
    OP_MVEQZ  = 4'd13,
    OP_MVNEZ  = 4'd14,
    OP_UNDEF  = 4'd15
  } vbm_op_e;

endpackage

// File: rtl/vbm_arith_unit.sv
module vbm_arith_unit
  import vbm_pkg::*;
#(
  parameter int XLEN = 64,
  localparam int SHW  = $clog2(XLEN),
  localparam int HALF = XLEN / 2
) (
  input  vbm_op_e          op,
  input  logic [XLEN-1:0]  a,
  input  logic [XLEN-1:0]  b,
  input  logic [SHW-1:0]   sh,
  input  logic [SHW-1:0]   msb,
  input  logic [SHW-1:0]   lsb,
  output logic [XLEN-1:0]  y
);

  logic [XLEN-1:0] rot_full;
  logic [HALF-1:0] w_src;
  logic [HALF-1:0] w_rot;
  logic [SHW-2:0]  w_sh;
  logic [SHW:0]    up_amt;
  logic [SHW:0]    dn_amt;
  logic [XLEN-1:0] up_val;
  logic [XLEN-1:0] ext_s;
  logic [XLEN-1:0] ext_u;

  always_comb begin
    rot_full = (a >> sh) | (a << (XLEN - int'(sh)));
    w_src    = a[HALF-1:0];
    w_sh     = sh[SHW-2:0];
    w_rot    = (w_src >> w_sh) | (w_src << (HALF - int'(w_sh)));
    // left-justify the field, then shift it back down
    up_amt   = (SHW+1)'(XLEN-1) - {1'b0, msb};
    dn_amt   = up_amt + {1'b0, lsb};
    up_val   = a << up_amt;
    ext_s    = XLEN'($signed(up_val) >>> dn_amt);
    ext_u    = up_val >> dn_amt;
  end

  always_comb begin
    unique case (op)
      OP_SADD1: y = a + (b << 1);
      OP_SADD2: y = a + (b << 2);
      OP_SADD3: y = a + (b << 3);
      OP_ROR:   y = rot_full;
      OP_RORW:  y = {{HALF{w_rot[HALF-1]}}, w_rot};
      OP_EXTS:  y = ext_s;
      OP_EXTU:  y = ext_u;
      default:  y = '0;
    endcase
  end

endmodule

// File: rtl/vbm_lead_count.sv
module vbm_lead_count #(
  parameter int W = 64,
  localparam int CW = $clog2(W) + 1
) (
  input  logic [W-1:0]  v,
  output logic [CW-1:0] cnt
);

  logic hit;

  always_comb begin
    cnt = '0;
    hit = 1'b0;
    for (int i = W - 1; i >= 0; i--) begin
      if (!hit) begin
        if (v[i]) hit = 1'b1;
        else      cnt = cnt + 1'b1;
      end
    end
  end

endmodule

// File: rtl/vbm_byte_unit.sv
module vbm_byte_unit
  import vbm_pkg::*;
#(
  parameter int XLEN = 64,
  localparam int SHW  = $clog2(XLEN),
  localparam int NB   = XLEN / 8,
  localparam int HALF = XLEN / 2,
  localparam int HNB  = NB / 2
) (
  input  vbm_op_e          op,
  input  logic [XLEN-1:0]  a,
  input  logic [SHW-1:0]   sh,
  output logic [XLEN-1:0]  y
);

  logic [XLEN-1:0] rev_full;
  logic [HALF-1:0] rev_word;
  logic [XLEN-1:0] zmask;

  for (genvar g = 0; g < NB; g++) begin : g_lane
    assign rev_full[8*g +: 8] = a[8*(NB-1-g) +: 8];
    assign zmask[8*g +: 8]    = (a[8*g +: 8] == 8'h00) ? 8'hFF : 8'h00;
  end

  for (genvar g = 0; g < HNB; g++) begin : g_wlane
    assign rev_word[8*g +: 8] = a[8*(HNB-1-g) +: 8];
  end

  always_comb begin
    unique case (op)
      OP_REV:   y = rev_full;
      OP_REVW:  y = {{HALF{rev_word[HALF-1]}}, rev_word};
      OP_ZBYTE: y = zmask;
      OP_BTEST: y = {{(XLEN-1){1'b0}}, a[sh]};
      default:  y = '0;
    endcase
  end

endmodule

// File: rtl/vbm_alu.sv
module vbm_alu
  import vbm_pkg::*;
#(
  parameter int XLEN = 64,
  localparam int SHW = $clog2(XLEN),
  localparam int CW  = SHW + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             op_valid,
  input  logic [3:0]       op_code,
  input  logic [XLEN-1:0]  src_a,
  input  logic [XLEN-1:0]  src_b,
  input  logic [XLEN-1:0]  src_old,
  input  logic [SHW-1:0]   imm_sh,
  input  logic [SHW-1:0]   imm_msb,
  input  logic [SHW-1:0]   imm_lsb,
  output logic [XLEN-1:0]  res,
  output logic             wr_en,
  output logic             illegal
);

  vbm_op_e         op;
  logic [XLEN-1:0] arith_y;
  logic [XLEN-1:0] byte_y;
  logic [CW-1:0]   clo_cnt;
  logic [CW-1:0]   clz_cnt;
  logic            bad_field;
  logic            bad_op;
  logic            reject;
  logic [XLEN-1:0] res_d;
  logic            wr_d;
  logic            ill_d;

  assign op = vbm_op_e'(op_code);

  vbm_arith_unit #(.XLEN(XLEN)) u_arith (
    .op (op), .a (src_a), .b (src_b), .sh (imm_sh),
    .msb(imm_msb), .lsb(imm_lsb), .y (arith_y)
  );

  vbm_lead_count #(.W(XLEN)) u_clo (.v(~src_a), .cnt(clo_cnt));
  vbm_lead_count #(.W(XLEN)) u_clz (.v(src_a),  .cnt(clz_cnt));

  vbm_byte_unit #(.XLEN(XLEN)) u_byte (
    .op(op), .a(src_a), .sh(imm_sh), .y(byte_y)
  );

  // next-state
  always_comb begin
    bad_field = ((op == OP_EXTS) || (op == OP_EXTU)) && (imm_lsb > imm_msb);
    bad_op    = (op == OP_UNDEF);
    reject    = bad_field || bad_op;
    unique case (op)
      OP_CLO:   res_d = {{(XLEN-CW){1'b0}}, clo_cnt};
      OP_CLZ:   res_d = {{(XLEN-CW){1'b0}}, clz_cnt};
      OP_REV, OP_REVW, OP_ZBYTE, OP_BTEST: res_d = byte_y;
      OP_MVEQZ: res_d = (src_b == '0) ? src_a : src_old;
      OP_MVNEZ: res_d = (src_b != '0) ? src_a : src_old;
      OP_UNDEF: res_d = '0;
      default:  res_d = arith_y;
    endcase
    if (reject) res_d = '0;
    wr_d  = op_valid && !reject;
    ill_d = op_valid && reject;
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res     <= '0;
      wr_en   <= 1'b0;
      illegal <= 1'b0;
    end else begin
      wr_en   <= wr_d;
      illegal <= ill_d;
      if (op_valid) res <= res_d;
    end
  end

endmodule

// File: rtl/vbm_alu_chk.sv
module vbm_alu_chk #(
  parameter int XLEN = 64,
  localparam int SHW = $clog2(XLEN)
) (
  input logic            clk,
  input logic            rst_n,
  input logic            op_valid,
  input logic [3:0]      op_code,
  input logic [XLEN-1:0] src_b,
  input logic [XLEN-1:0] src_old,
  input logic [SHW-1:0]  imm_msb,
  input logic [SHW-1:0]  imm_lsb,
  input logic [XLEN-1:0] res,
  input logic            wr_en,
  input logic            illegal
);

  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !op_valid |=> (!wr_en && !illegal));

  assert_strobe_excl_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && illegal));

  assert_bad_field_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && (op_code == 4'd5 || op_code == 4'd6) && imm_lsb > imm_msb)
    |=> (illegal && !wr_en && res == '0));

  assert_undef_op_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_code == 4'd15) |=> (illegal && res == '0));

  assert_bit_only_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_code == 4'd12) |=> (wr_en && res[XLEN-1:1] == '0));

  assert_keep_old_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_code == 4'd13 && src_b != '0) |=> (res == $past(src_old)));

  assert_count_range_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && (op_code == 4'd7 || op_code == 4'd8)) |=> (res <= XLEN));

endmodule

bind vbm_alu vbm_alu_chk #(.XLEN(XLEN)) u_chk (
  .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
  .src_b(src_b), .src_old(src_old), .imm_msb(imm_msb), .imm_lsb(imm_lsb),
  .res(res), .wr_en(wr_en), .illegal(illegal)
);

// File: tb/vbm_alu_test.sv
module vbm_alu_test;

  localparam int CLK_PERIOD = 10;

  logic        clk;
  logic        rst_n;
  logic        op_valid;
  logic [3:0]  op_code;
  logic [63:0] src_a, src_b, src_old;
  logic [5:0]  imm_sh, imm_msb, imm_lsb;
  logic [63:0] res;
  logic        wr_en, illegal;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  vbm_alu uut (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
    .src_a(src_a), .src_b(src_b), .src_old(src_old), .imm_sh(imm_sh),
    .imm_msb(imm_msb), .imm_lsb(imm_lsb), .res(res), .wr_en(wr_en),
    .illegal(illegal)
  );

  initial clk = 0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // drive one request, then check all outputs half a period after capture
  task automatic run(string req, logic [3:0] code, logic [63:0] a, logic [63:0] b,
                     logic [63:0] old, logic [5:0] sh, logic [5:0] hi, logic [5:0] lo,
                     logic [63:0] exp_res, logic exp_wr, logic exp_ill);
    @(negedge clk);
    op_valid = 1; op_code = code; src_a = a; src_b = b; src_old = old;
    imm_sh = sh; imm_msb = hi; imm_lsb = lo;
    @(negedge clk);
    op_valid = 0;
    chk(req, res, exp_res);
    chk(req, {63'd0, wr_en}, {63'd0, exp_wr});
    chk(req, {63'd0, illegal}, {63'd0, exp_ill});
  endtask

  function automatic logic [63:0] lz(logic [63:0] v);
    for (int i = 0; i < 64; i++) if (v[63-i]) return 64'(i);
    return 64'd64;
  endfunction

  task automatic t_reset;
    chk("R1 reset res", res, 64'd0);
    chk("R1 reset strobes", {62'd0, wr_en, illegal}, 64'd0);
  endtask

  task automatic t_scaled_add;
    run("R2 n1", 4'd0, 64'd100, 64'd7, 0, 0, 0, 0, 64'd114, 1, 0);
    run("R2 n2", 4'd1, 64'd100, 64'd7, 0, 0, 0, 0, 64'd128, 1, 0);
    run("R2 n3 wrap", 4'd2, 64'd5, 64'h2000_0000_0000_0001, 0, 0, 0, 0, 64'd13, 1, 0);
  endtask

  task automatic t_rotate;
    run("R3 ror", 4'd3, 64'h0123_4567_89AB_CDEF, 0, 0, 6'd4, 0, 0,
        64'hF012_3456_789A_BCDE, 1, 0);
    run("R3 ror0", 4'd3, 64'h0123_4567_89AB_CDEF, 0, 0, 6'd0, 0, 0,
        64'h0123_4567_89AB_CDEF, 1, 0);
    run("R3 rorw neg", 4'd4, 64'h0123_4567_0000_00F1, 0, 0, 6'd8, 0, 0,
        64'hFFFF_FFFF_F100_0000, 1, 0);
    run("R3 rorw pos", 4'd4, 64'hFFFF_FFFF_0000_0010, 0, 0, 6'd36, 0, 0,
        64'h0000_0000_0000_0001, 1, 0);
  endtask

  task automatic t_extract;
    run("R4 exts", 4'd5, 64'h0000_0000_0000_00F0, 0, 0, 0, 6'd7, 6'd4,
        64'hFFFF_FFFF_FFFF_FFFF, 1, 0);
    run("R4 extu", 4'd6, 64'h0000_0000_0000_00F0, 0, 0, 0, 6'd7, 6'd4, 64'hF, 1, 0);
    run("R4 exts pos", 4'd5, 64'h0000_0000_0000_0070, 0, 0, 0, 6'd7, 6'd4, 64'h7, 1, 0);
    run("R4 full", 4'd5, 64'h8123_4567_89AB_CDEF, 0, 0, 0, 6'd63, 6'd0,
        64'h8123_4567_89AB_CDEF, 1, 0);
    run("R4 single", 4'd6, 64'h8000_0000_0000_0000, 0, 0, 0, 6'd63, 6'd63, 64'd1, 1, 0);
    run("R5 lsb>msb", 4'd6, 64'hFFFF, 0, 0, 0, 6'd3, 6'd4, 64'd0, 0, 1);
  endtask

  task automatic t_count;
    run("R6 clo all ones", 4'd7, '1, 0, 0, 0, 0, 0, lz(~64'hFFFF_FFFF_FFFF_FFFF), 1, 0);
    run("R6 clo 12", 4'd7, 64'hFFF0_0000_0000_0000, 0, 0, 0, 0, 0, 64'd12, 1, 0);
    run("R6 clz zero", 4'd8, 64'd0, 0, 0, 0, 0, 0, 64'd64, 1, 0);
    run("R6 clz one", 4'd8, 64'd1, 0, 0, 0, 0, 0, lz(64'd1), 1, 0);
  endtask

  task automatic t_bytes;
    run("R7 rev", 4'd9, 64'h0102_0304_0506_0708, 0, 0, 0, 0, 0,
        64'h0807_0605_0403_0201, 1, 0);
    run("R7 revw", 4'd10, 64'hAAAA_AAAA_1234_5680, 0, 0, 0, 0, 0,
        64'hFFFF_FFFF_8056_3412, 1, 0);
    run("R8 zbyte", 4'd11, 64'h1200_3400_0056_0078, 0, 0, 0, 0, 0,
        64'h00FF_00FF_FF00_FF00, 1, 0);
    run("R9 btest 63", 4'd12, 64'h8000_0000_0000_0000, 0, 0, 6'd63, 0, 0, 64'd1, 1, 0);
    run("R9 btest clear", 4'd12, 64'hFFFF_FFFF_FFFF_FFEF, 0, 0, 6'd4, 0, 0, 64'd0, 1, 0);
  endtask

  task automatic t_cmov;
    run("R10 mveqz take", 4'd13, 64'hA5, 64'd0, 64'h77, 0, 0, 0, 64'hA5, 1, 0);
    run("R10 mveqz keep", 4'd13, 64'hA5, 64'd5, 64'h77, 0, 0, 0, 64'h77, 1, 0);
    run("R10 mvnez take", 4'd14, 64'hA5, 64'd5, 64'h77, 0, 0, 0, 64'hA5, 1, 0);
    run("R10 mvnez keep", 4'd14, 64'hA5, 64'd0, 64'h77, 0, 0, 0, 64'h77, 1, 0);
  endtask

  task automatic t_undef_idle;
    run("R11 undef", 4'd15, 64'h1234, 64'h1, 64'h2, 0, 0, 0, 64'd0, 0, 1);
    run("R1 hold src", 4'd8, 64'd1, 0, 0, 0, 0, 0, 64'd63, 1, 0);
    @(negedge clk);  // idle cycle: strobes drop, result held
    chk("R1 idle hold", res, 64'd63);
    chk("R1 idle strobes", {62'd0, wr_en, illegal}, 64'd0);
  endtask

  task automatic finish_run;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    rst_n = 0; op_valid = 0; op_code = 0; src_a = 0; src_b = 0; src_old = 0;
    imm_sh = 0; imm_msb = 0; imm_lsb = 0;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_scaled_add();
    t_rotate();
    t_extract();
    t_count();
    t_bytes();
    t_cmov();
    t_undef_idle();
    done = 1;
    finish_run();
  end

  initial begin
    #(CLK_PERIOD * 5000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      finish_run();
    end
  end

endmodule